// File: doc/BRIEF.md
# EEPROM Page Write Buffer Engine

This block gathers the data bytes of one page write for a serial EEPROM model and commits them to the storage array once the bus master ends the command. A command begins with a start address, continues with any number of data byte strobes, and ends with a stop strobe. Every accepted byte goes into a 64-entry page buffer at the in-page offset of the address pointer. Only the offset bits of the pointer advance, so a long burst wraps back to the first byte of the same physical page, and later bytes overwrite earlier ones.

At the stop, the write-protect input is sampled once. If it is low and at least one byte was collected, a write cycle of fixed length starts on the next clock. During that cycle every location of the page is rewritten through the array's write port. Collected bytes take their new values, and every other byte is read back through the array's read port and written again unchanged. A `busy` flag stays high for the whole cycle. The protocol layer uses it to withhold acknowledges, and this block ignores all strobes while it is high. A protected stop, or a stop with no data, leaves the array alone and the engine ready at once.

Top module: `pgwr_engine`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy` and `mem_we` are 0 and `cur_addr` is 0.
- R2: A `start_valid` pulse while idle loads `start_addr` into `cur_addr` on the next clock and discards any bytes collected so far.
- R3: Each accepted `byte_valid` stores `byte_data` at the page offset `cur_addr[5:0]` and adds 1 to `cur_addr[5:0]` modulo 64, leaving `cur_addr[13:6]` unchanged.
- R4: When more than 64 bytes arrive before the stop, a later byte replaces the earlier byte at the same offset, and only the last value per offset is committed.
- R5: A stop while idle, with `wp` low and at least one collected byte, raises `busy` on the next clock and holds it for exactly `WR_CYCLES` cycles (`WR_CYCLES` is at least 65).
- R6: During a write cycle, `mem_we` pulses exactly 64 times, once for each address of the page selected by `cur_addr[13:6]` and for no address outside it. Collected offsets get their new byte, and every other offset keeps its prior contents.
- R7: A stop with `wp` high writes nothing, leaves `busy` low, and a new start is accepted on the following clock.
- R8: Changes on `wp` after the stop do not affect the running write cycle.
- R9: A stop with no collected byte starts no write cycle.
- R10: While `busy` is high, `start_valid`, `byte_valid` and `stop` are ignored, and `cur_addr` and the collected bytes are unchanged.
- R11: After a committed write, `cur_addr` holds the address after the last byte written. After a single byte at address A, it holds A+1 within the page.
- R12: In one idle cycle, `stop` takes priority over `start_valid`, which takes priority over `byte_valid`. The lower-priority strobe in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Load the start address of a new command |
| start_addr | input | 14 | Byte address loaded into the pointer |
| byte_valid | input | 1 | One data byte received |
| byte_data | input | 8 | Received data byte |
| stop | input | 1 | End of command |
| wp | input | 1 | Write protect, sampled at the stop |
| busy | output | 1 | Write cycle running; acknowledges are withheld |
| cur_addr | output | 14 | Current address pointer |
| mem_we | output | 1 | Array write enable |
| mem_waddr | output | 14 | Array write address |
| mem_wdata | output | 8 | Array write data |
| mem_raddr | output | 14 | Array read address (one-cycle read latency) |
| mem_rdata | input | 8 | Array read data for `mem_raddr` of the previous cycle |

## Verification
The checker watches on every cycle that array writes only occur while busy and stay inside the pointer's page, that busy only rises after an unprotected stop, that each write cycle has the exact length and exactly 64 writes, and that the pointer steps only its offset bits and holds still while busy. Only the bench's scenarios can show that the right values land in the array: wrapped and overwritten bursts, untouched bytes kept, protected or empty stops leaving the array alone, strobes dropped during busy, and same-cycle priority. A behavioural model supplies the expected array contents and pointer for these.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } pgwr_state_e;

    // Per-cycle decision taken from the strobes while idle
    typedef struct packed {
        logic load;     // take a new start address
        logic store;    // put one byte into the page buffer
        logic commit;   // begin the page write cycle
        logic discard;  // forget collected bytes
    } pgwr_event_t;

    // Write cycle length: the sweep needs one cycle per page byte plus one
    function automatic int unsigned pgwr_cycle_len(int unsigned req, int unsigned page);
        return (req > page) ? req : page + 1;
    endfunction

    // Priority: stop, then start, then data byte; nothing while busy
    function automatic pgwr_event_t pgwr_decode(logic busy_i, logic stop_i, logic start_i,
                                                logic data_i, logic have_i, logic wp_i);
        pgwr_event_t ev;
        ev = '0;
        if (!busy_i) begin
            if (stop_i) begin
                ev.commit  = have_i && !wp_i;
                ev.discard = !(have_i && !wp_i);
            end else if (start_i) begin
                ev.load    = 1'b1;
                ev.discard = 1'b1;
            end else if (data_i) begin
                ev.store   = 1'b1;
            end
        end
        return ev;
    endfunction

endpackage

// File: rtl/pgwr_ptr.sv
module pgwr_ptr #(
    parameter int ADDR_W = 14,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);
    localparam int HI_W = ADDR_W - PAGE_W;

    logic [HI_W-1:0]   page_q;
    logic [PAGE_W-1:0] off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            off_q  <= '0;
        end else if (load) begin
            page_q <= load_addr[ADDR_W-1:PAGE_W];
            off_q  <= load_addr[PAGE_W-1:0];
        end else if (step) begin
            off_q  <= off_q + 1'b1;   // offset wraps, page bits stay
        end
    end

    assign ptr = {page_q, off_q};
endmodule

// File: rtl/pgwr_buf.sv
module pgwr_buf #(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr,
    input  logic [PAGE_W-1:0] wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PAGE_W-1:0] rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_hit,
    output logic              any
);
    localparam int PAGE = 1 << PAGE_W;

    logic [DATA_W-1:0] slot_q [PAGE];
    logic [PAGE-1:0]   fill_q;

    for (genvar g = 0; g < PAGE; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr && wr_off == PAGE_W'(g)) begin
                slot_q[g] <= wr_data;
            end
        end
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                fill_q[g] <= 1'b0;
            end else if (wr && wr_off == PAGE_W'(g)) begin
                fill_q[g] <= 1'b1;
            end
        end
    end

    assign rd_data = slot_q[rd_off];
    assign rd_hit  = fill_q[rd_off];
    assign any     = |fill_q;
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
    import pgwr_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int PAGE_W = 6,
    parameter int CYC    = 80
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     commit,
    input  logic [ADDR_W-PAGE_W-1:0] page_in,
    output logic                     busy,
    output logic                     fin,
    output logic [ADDR_W-1:0]        raddr,
    output logic                     we,
    output logic [ADDR_W-1:0]        waddr,
    output logic [PAGE_W-1:0]        wr_off
);
    localparam int HI_W  = ADDR_W - PAGE_W;
    localparam int PAGE  = 1 << PAGE_W;
    localparam int CNT_W = $clog2(CYC + 1);

    pgwr_state_e      st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_m1;
    logic [HI_W-1:0]  page_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            page_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (commit) begin
                        st_q   <= ST_WRITE;
                        cnt_q  <= '0;
                        page_q <= page_in;
                    end
                end
                ST_WRITE: begin
                    if (fin) begin
                        st_q  <= ST_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Sweep: read offset k in count k, write offset k in count k+1
    assign cnt_m1 = cnt_q - 1'b1;
    assign busy   = (st_q == ST_WRITE);
    assign fin    = busy && (cnt_q == CNT_W'(CYC - 1));
    assign raddr  = {page_q, cnt_q[PAGE_W-1:0]};
    assign we     = busy && (cnt_q != '0) && (cnt_q <= CNT_W'(PAGE));
    assign wr_off = cnt_m1[PAGE_W-1:0];
    assign waddr  = {page_q, wr_off};
endmodule

// File: rtl/pgwr_engine.sv
module pgwr_engine
    import pgwr_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int DATA_W    = 8,
    parameter int PAGE_W    = 6,
    parameter int WR_CYCLES = 80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_valid,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop,
    input  logic              wp,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int CYC = int'(pgwr_cycle_len(WR_CYCLES, 1 << PAGE_W));

    pgwr_event_t       ev;
    logic              have;
    logic              fin;
    logic [PAGE_W-1:0] sweep_off;
    logic [DATA_W-1:0] held_data;
    logic              held_hit;

    assign ev = pgwr_decode(busy, stop, start_valid, byte_valid, have, wp);

    pgwr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .load      (ev.load),
        .load_addr (start_addr),
        .step      (ev.store),
        .ptr       (cur_addr)
    );

    pgwr_buf #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .clear   (ev.discard || fin),
        .wr      (ev.store),
        .wr_off  (cur_addr[PAGE_W-1:0]),
        .wr_data (byte_data),
        .rd_off  (sweep_off),
        .rd_data (held_data),
        .rd_hit  (held_hit),
        .any     (have)
    );

    pgwr_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CYC(CYC)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .commit  (ev.commit),
        .page_in (cur_addr[ADDR_W-1:PAGE_W]),
        .busy    (busy),
        .fin     (fin),
        .raddr   (mem_raddr),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wr_off  (sweep_off)
    );

    // Collected byte wins; otherwise refresh with the array's own value
    assign mem_wdata = held_hit ? held_data : mem_rdata;
endmodule

// File: rtl/pgwr_engine_chk.sv
module pgwr_engine_chk
    import pgwr_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int DATA_W    = 8,
    parameter int PAGE_W    = 6,
    parameter int WR_CYCLES = 80
) (
    input logic              clk,
    input logic              rst,
    input logic              start_valid,
    input logic              byte_valid,
    input logic              stop,
    input logic              wp,
    input logic              busy,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_waddr
);
    localparam int CYC  = int'(pgwr_cycle_len(WR_CYCLES, 1 << PAGE_W));
    localparam int PAGE = 1 << PAGE_W;
    localparam int CW   = $clog2(CYC + 2) + 1;

    logic [CW-1:0] wcount_q;
    logic [CW-1:0] blen_q;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            wcount_q <= '0;
            blen_q   <= '0;
        end else begin
            blen_q <= blen_q + 1'b1;
            if (mem_we) wcount_q <= wcount_q + 1'b1;
        end
    end

    AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);  // R7

    AST_WE_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_waddr[ADDR_W-1:PAGE_W] == cur_addr[ADDR_W-1:PAGE_W]);  // R6

    AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(stop) && !$past(wp)));  // R5

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> blen_q == CW'(CYC));  // R5

    AST_WRITE_COUNT: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> wcount_q == CW'(PAGE));  // R6

    AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cur_addr));  // R10

    AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (rst)
        (!busy && byte_valid && !stop && !start_valid) |=>
        (cur_addr[ADDR_W-1:PAGE_W] == $past(cur_addr[ADDR_W-1:PAGE_W]) &&
         cur_addr[PAGE_W-1:0] == $past(cur_addr[PAGE_W-1:0]) + 1'b1));  // R3
endmodule

bind pgwr_engine pgwr_engine_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_valid (start_valid),
    .byte_valid  (byte_valid),
    .stop        (stop),
    .wp          (wp),
    .busy        (busy),
    .cur_addr    (cur_addr),
    .mem_we      (mem_we),
    .mem_waddr   (mem_waddr)
);

// File: tb/pgwr_engine_test.sv
module pgwr_engine_test;
    localparam int AW   = 14;
    localparam int DW   = 8;
    localparam int PW   = 6;
    localparam int PAGE = 64;
    localparam int WRC  = 80;

    logic          clk = 1'b0;
    logic          rst;
    logic          start_valid, byte_valid, stop, wp;
    logic [AW-1:0] start_addr;
    logic [DW-1:0] byte_data;
    logic          busy, mem_we;
    logic [AW-1:0] cur_addr, mem_waddr, mem_raddr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pgwr_engine #(.ADDR_W(AW), .DATA_W(DW), .PAGE_W(PW), .WR_CYCLES(WRC)) uut (
        .clk(clk), .rst(rst), .start_valid(start_valid), .start_addr(start_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .stop(stop), .wp(wp),
        .busy(busy), .cur_addr(cur_addr), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] seedv(int a);
        return 8'(a * 37 + 11);
    endfunction

    // Array model seen by the design
    logic [7:0] ram [int];
    function automatic logic [7:0] ram_rd(int a);
        return ram.exists(a) ? ram[a] : seedv(a);
    endfunction

    always @(posedge clk) begin
        logic [7:0] rv;
        rv = ram_rd(int'(mem_raddr));
        if (mem_we) ram[int'(mem_waddr)] = mem_wdata;
        mem_rdata <= rv;
    end

    // Behavioural reference
    logic [7:0] refm [int];
    logic [7:0] pend [int];
    int         r_rem = 0;
    logic [13:0] r_ptr = '0;
    int         r_base = 0;
    int         we_seen = 0;
    bit         prev_busy = 0;

    function automatic logic [7:0] ref_rd(int a);
        return refm.exists(a) ? refm[a] : seedv(a);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            r_rem = 0;
            r_ptr = '0;
            pend.delete();
        end else if (r_rem > 0) begin
            r_rem--;                                   // R10 strobes ignored
        end else if (stop) begin                       // R12 stop first
            if (pend.num() > 0 && !wp) begin
                r_base = int'(r_ptr[13:6]) * PAGE;
                for (int i = 0; i < PAGE; i++)
                    refm[r_base + i] = pend.exists(i) ? pend[i] : ref_rd(r_base + i);
                r_rem = WRC;
            end
            pend.delete();
        end else if (start_valid) begin
            r_ptr = start_addr;
            pend.delete();
        end else if (byte_valid) begin
            pend[int'(r_ptr[5:0])] = byte_data;
            r_ptr[5:0] = r_ptr[5:0] + 6'd1;
        end
    end

    always @(posedge clk) begin
        #3;
        if (!rst && !done) begin
            chk("R5 busy", 32'(busy), 32'(r_rem > 0));
            chk("R3 pointer", 32'(cur_addr), 32'(r_ptr));
            if (r_rem == 0) chk("R7 no write when idle", 32'(mem_we), 32'd0);
            if (mem_we) begin
                we_seen++;
                chk("R6 write inside page", 32'(int'(mem_waddr) / PAGE), 32'(r_base / PAGE));
            end
            if (prev_busy && !busy) begin
                chk("R6 writes per cycle", 32'(we_seen), 32'(PAGE));
                for (int i = 0; i < PAGE; i++)
                    chk("R6 page contents", 32'(ram_rd(r_base + i)), 32'(ref_rd(r_base + i)));
                we_seen = 0;
            end
            prev_busy = busy;
        end
    end

    task automatic clr();
        start_valid = 0; byte_valid = 0; stop = 0;
    endtask
    task automatic p_start(logic [13:0] a);
        @(negedge clk); clr(); start_valid = 1; start_addr = a;
    endtask
    task automatic p_byte(logic [7:0] d);
        @(negedge clk); clr(); byte_valid = 1; byte_data = d;
    endtask
    task automatic p_stop(logic w);
        @(negedge clk); clr(); stop = 1; wp = w;
    endtask
    task automatic gap(int n);
        @(negedge clk); clr();
        repeat (n) @(negedge clk);
    endtask
    task automatic wait_idle();
        @(negedge clk); clr();
        while (busy) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1; clr(); wp = 0; start_addr = '0; byte_data = '0;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", 32'(busy), 0);
        chk("R1 we in reset", 32'(mem_we), 0);
        chk("R1 pointer in reset", 32'(cur_addr), 0);
        rst = 0;

        // R2 R11 single byte
        p_start(14'h0105);
        p_byte(8'hA5);
        @(negedge clk); clr();
        chk("R11 pointer after one byte", 32'(cur_addr), 32'h0106);
        p_stop(1'b0);
        @(negedge clk); clr();
        chk("R5 busy after stop", 32'(busy), 1);
        wait_idle();
        chk("R11 pointer after commit", 32'(cur_addr), 32'h0106);
        chk("R6 written byte", 32'(ram_rd(32'h0105)), 32'hA5);
        chk("R6 neighbour kept", 32'(ram_rd(32'h0104)), 32'(seedv(32'h0104)));

        // R3 wrap inside page
        p_start(14'h013E);
        p_byte(8'h11); p_byte(8'h22); p_byte(8'h33);
        p_stop(1'b0);
        wait_idle();
        chk("R3 wrapped to page start", 32'(ram_rd(32'h0100)), 32'h33);
        chk("R3 next page untouched", 32'(ram_rd(32'h0140)), 32'(seedv(32'h0140)));
        chk("R3 page bits kept", 32'(cur_addr), 32'h0101);

        // R4 70 bytes overwrite the first six
        p_start(14'h0200);
        for (int i = 0; i < 70; i++) p_byte(8'(i + 1));
        p_stop(1'b0);
        wait_idle();
        chk("R4 overwritten offset 0", 32'(ram_rd(32'h0200)), 32'd65);
        chk("R4 offset 6 first pass", 32'(ram_rd(32'h0206)), 32'd7);

        // R7 protected stop, new start next clock
        p_start(14'h0300);
        p_byte(8'h5A);
        p_stop(1'b1);
        p_start(14'h0310);
        @(negedge clk); clr();
        chk("R7 busy stays low", 32'(busy), 0);
        chk("R7 start accepted at once", 32'(cur_addr), 32'h0310);
        chk("R7 array unchanged", 32'(ram_rd(32'h0300)), 32'(seedv(32'h0300)));

        // R8 wp toggled during the cycle; R10 strobes during busy
        p_start(14'h0400);
        p_byte(8'hC3);
        p_stop(1'b0);
        p_stop(1'b1);
        p_start(14'h0777);
        p_byte(8'hEE);
        @(negedge clk); clr(); wp = 0;
        chk("R10 pointer held while busy", 32'(cur_addr), 32'h0401);
        wait_idle();
        chk("R8 write done despite wp", 32'(ram_rd(32'h0400)), 32'hC3);
        chk("R10 byte during busy dropped", 32'(ram_rd(32'h0401)), 32'(seedv(32'h0401)));

        // R9 stop with no data
        p_start(14'h0500);
        p_stop(1'b0);
        @(negedge clk); clr();
        chk("R9 no cycle without data", 32'(busy), 0);

        // R12 same-cycle priority and start discarding bytes
        p_start(14'h0600);
        p_byte(8'h01);
        @(negedge clk); clr(); start_valid = 1; start_addr = 14'h0620; byte_valid = 1; byte_data = 8'h99;
        @(negedge clk); clr();
        chk("R12 start over byte", 32'(cur_addr), 32'h0620);
        p_byte(8'h42);
        @(negedge clk); clr(); stop = 1; wp = 0; byte_valid = 1; byte_data = 8'h77;
        wait_idle();
        chk("R12 byte with stop dropped", 32'(cur_addr), 32'h0621);
        chk("R2 earlier byte discarded", 32'(ram_rd(32'h0600)), 32'(seedv(32'h0600)));
        chk("R12 committed byte", 32'(ram_rd(32'h0620)), 32'h42);

        gap(4);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule